// File: doc/BRIEF.md
# Video Post-Processing Command Front End

This block is the command front end of a video post-processing engine. Software issues method writes, each carrying a method number and a 32-bit argument. Every write is mirrored into a word-addressed state register file. Four methods also latch a 256-byte-aligned base address: configuration, luma, chroma-U and chroma-V. Each of these addresses is the 32-bit argument shifted left by eight bits, which gives a 40-bit byte address.

An Execute method starts a job. If the luma base is still zero, the block reports an error and does nothing else. Otherwise it issues one read of a 64-bit configuration word at configuration base plus 0x20 and waits for the response. It then decodes the word and either pulses `start` toward the selected output path, together with the decoded geometry, or pulses an unsupported-format error.

The controller is a four-state machine:

- IDLE: waiting for a method.
  - IDLE→REQ when Execute arrives and the luma base is nonzero.
  - IDLE→IDLE when Execute arrives with a zero luma base; a no-luma error pulse follows.
- REQ: drives the one-cycle read request.
  - REQ→WAIT always.
- WAIT: holds until the read data is valid.
  - WAIT→DONE when the read data is valid.
- DONE: issues `start` or the format error.
  - DONE→IDLE always.

Top module: `vpp_cmd_frontend`

## Requirements
- R1: Every accepted method write stores its argument in state word `mw_idx`, which `rd_data` shows for `rd_idx` from the next cycle; reset clears all words to zero.
- R2: Methods 0x10 (config), 0x11 (luma), 0x12 (chroma-U) and 0x13 (chroma-V) latch `{mw_arg, 8'h00}` into their 40-bit base output from the next cycle. Reset clears all four bases to zero.
- R3: Execute (method 0x08) while idle with a zero luma base raises `err_noluma` for exactly the next cycle, issues no read and leaves `busy` low.
- R4: Execute while idle with a nonzero luma base raises `mem_req` for exactly the next cycle, with `mem_addr` equal to the config base plus 0x20.
- R5: `busy` is high from the request cycle through the cycle of `start`/`err_fmt`. An Execute arriving while busy issues no further read.
- R6: Config format field bits [3:0] of value 1, 2 or 3 give `start` with `path` 0 (RGBA), 1 (BGRA) or 2 (YUV 4:2:0). Any other value gives `err_fmt` instead of `start`, and the two never occur together.
- R7: `swz` is 1 only for RGBA/BGRA with a nonzero block-kind field (bits [7:4]); it is 0 for YUV.
- R8: `start` lasts exactly one cycle, one cycle after the read data is accepted. With it, `blk_kind`=[7:4], `blk_h`=[10:8], `w_m1`=[25:12] and `h_m1`=[39:26] are shown.
- R9: Methods other than Execute never raise `busy` or `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mw_valid | input | 1 | Method write strobe |
| mw_idx | input | 6 | Method number |
| mw_arg | input | 32 | Method argument |
| rd_idx | input | 6 | State word select |
| rd_data | output | 32 | Selected state word |
| cfg_base | output | 40 | Configuration base byte address |
| luma_base | output | 40 | Luma surface base |
| chu_base | output | 40 | Chroma-U surface base |
| chv_base | output | 40 | Chroma-V surface base |
| mem_req | output | 1 | Config read request (one cycle) |
| mem_addr | output | 40 | Config read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Job in progress |
| start | output | 1 | Start pulse to the output path |
| path | output | 2 | 0 RGBA, 1 BGRA, 2 YUV |
| swz | output | 1 | Block-linear output selected |
| blk_kind | output | 4 | Block-linear kind field |
| blk_h | output | 3 | Block height log2 |
| w_m1 | output | 14 | Surface width minus one |
| h_m1 | output | 14 | Surface height minus one |
| err_noluma | output | 1 | Execute refused, luma base zero |
| err_fmt | output | 1 | Unsupported pixel format |

## Verification
A controller stuck outside IDLE shows as `busy` staying high, and no further `mem_req` appears for later Execute writes; the first such Execute exposes it one cycle later. A controller that skips REQ or DONE shows as a missing read pulse, or as a missing or doubled `start`, in the cycle right after the trigger or the response. A wrong captured word or decode shows directly in `path`, `swz` and the geometry fields on the `start` cycle. A corrupted state word or base is visible through `rd_data` and the base outputs one cycle after the write.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int ALIGN_SH = 8;
    localparam int ADDR_W  = ARG_W + ALIGN_SH;
    localparam int CFG_W   = 64;
    localparam int N_BASE  = 4;
    localparam logic [ADDR_W-1:0] CFG_OFS = 40'h20;

    localparam logic [IDX_W-1:0] M_EXEC = 6'h08;
    localparam logic [IDX_W-1:0] M_CFG  = 6'h10;
    localparam logic [IDX_W-1:0] M_LUMA = 6'h11;
    localparam logic [IDX_W-1:0] M_CHU  = 6'h12;
    localparam logic [IDX_W-1:0] M_CHV  = 6'h13;

    typedef enum logic [1:0] {
        PATH_RGBA = 2'd0,
        PATH_BGRA = 2'd1,
        PATH_YUV  = 2'd2,
        PATH_NONE = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2,
        S_DONE = 2'd3
    } fsm_e;

    typedef struct packed {
        logic [13:0] h_m1;
        logic [13:0] w_m1;
        logic        rsvd;
        logic [2:0]  blk_h;
        logic [3:0]  kind;
        logic [3:0]  fmt;
    } cfg_t;
endpackage

// File: rtl/vpp_state_file.sv
module vpp_state_file #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

    AST_MIRROR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (words[$past(wr_idx)] == $past(wr_data)));   // R1
endmodule

// File: rtl/vpp_addr_latch.sv
module vpp_addr_latch #(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    parameter int SH    = 8,
    parameter int N     = 4,
    parameter logic [N*IDX_W-1:0] IDS = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [ARG_W-1:0]            wr_arg,
    output logic [N-1:0][ARG_W+SH-1:0]  base_o
);
    localparam int AW = ARG_W + SH;

    for (genvar g = 0; g < N; g++) begin : g_base
        localparam logic [IDX_W-1:0] MY_ID = IDS[g*IDX_W +: IDX_W];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g] <= '0;
            end else if (wr_en && (wr_idx == MY_ID)) begin
                base_o[g] <= {wr_arg, {SH{1'b0}}};
            end
        end

        AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            base_o[g][SH-1:0] == '0);   // R2
        AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == MY_ID) |=> $stable(base_o[g]));   // R2
    end

    logic [AW-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/vpp_cfg_decode.sv
module vpp_cfg_decode
    import vpp_pkg::*;
(
    input  logic [CFG_W-1:0] word,
    output path_e            path,
    output logic             fmt_ok,
    output logic             swz,
    output logic [3:0]       blk_kind,
    output logic [2:0]       blk_h,
    output logic [13:0]      w_m1,
    output logic [13:0]      h_m1
);
    cfg_t c;
    assign c = cfg_t'(word[$bits(cfg_t)-1:0]);

    always_comb begin
        unique case (c.fmt)
            4'd1:    path = PATH_RGBA;
            4'd2:    path = PATH_BGRA;
            4'd3:    path = PATH_YUV;
            default: path = PATH_NONE;
        endcase
    end

    assign fmt_ok   = (path != PATH_NONE);
    assign swz      = ((path == PATH_RGBA) || (path == PATH_BGRA)) && (c.kind != 4'd0);
    assign blk_kind = c.kind;
    assign blk_h    = c.blk_h;
    assign w_m1     = c.w_m1;
    assign h_m1     = c.h_m1;
endmodule

// File: rtl/vpp_exec_fsm.sv
module vpp_exec_fsm
    import vpp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_hit,
    input  logic             luma_zero,
    input  logic             mem_rvalid,
    input  logic [CFG_W-1:0] mem_rdata,
    input  logic             fmt_ok,
    input  path_e            path,
    input  logic             swz,
    output logic [CFG_W-1:0] word_q,
    output logic             mem_req,
    output logic             busy,
    output logic             start,
    output logic             err_fmt,
    output logic             err_noluma
);
    fsm_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (exec_hit && !luma_zero) nxt = S_REQ;
            S_REQ:  nxt = S_WAIT;
            S_WAIT: if (mem_rvalid) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q     <= '0;
            err_noluma <= 1'b0;
        end else begin
            err_noluma <= (state == S_IDLE) && exec_hit && luma_zero;
            if ((state == S_WAIT) && mem_rvalid) word_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req = (state == S_REQ);
        busy    = (state != S_IDLE);
        start   = (state == S_DONE) && fmt_ok;
        err_fmt = (state == S_DONE) && !fmt_ok;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);   // R8
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);   // R4
    AST_NOLUMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_noluma |-> !busy);   // R3
    AST_START_FMT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && err_fmt));   // R6
    AST_START_PATH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (path != PATH_NONE));   // R6
    AST_SWZ_YUV: assert property (@(posedge clk) disable iff (!rst_n)
        (start && path == PATH_YUV) |-> !swz);   // R7
    AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> busy);   // R5
endmodule

// File: rtl/vpp_cmd_frontend.sv
module vpp_cmd_frontend
    import vpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mw_valid,
    input  logic [IDX_W-1:0]  mw_idx,
    input  logic [ARG_W-1:0]  mw_arg,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ARG_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] cfg_base,
    output logic [ADDR_W-1:0] luma_base,
    output logic [ADDR_W-1:0] chu_base,
    output logic [ADDR_W-1:0] chv_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [CFG_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              start,
    output logic [1:0]        path,
    output logic              swz,
    output logic [3:0]        blk_kind,
    output logic [2:0]        blk_h,
    output logic [13:0]       w_m1,
    output logic [13:0]       h_m1,
    output logic              err_noluma,
    output logic              err_fmt
);
    logic [N_BASE-1:0][ADDR_W-1:0] bases;
    logic [CFG_W-1:0] word_q;
    logic  exec_hit, fmt_ok;
    path_e path_d;

    assign exec_hit = mw_valid && (mw_idx == M_EXEC);

    vpp_state_file #(.IDX_W(IDX_W), .DATA_W(ARG_W)) u_state (
        .clk(clk), .rst_n(rst_n), .wr_en(mw_valid), .wr_idx(mw_idx),
        .wr_data(mw_arg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    vpp_addr_latch #(
        .IDX_W(IDX_W), .ARG_W(ARG_W), .SH(ALIGN_SH), .N(N_BASE),
        .IDS({M_CHV, M_CHU, M_LUMA, M_CFG})
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .wr_en(mw_valid), .wr_idx(mw_idx),
        .wr_arg(mw_arg), .base_o(bases)
    );

    assign cfg_base  = bases[0];
    assign luma_base = bases[1];
    assign chu_base  = bases[2];
    assign chv_base  = bases[3];
    assign mem_addr  = cfg_base + CFG_OFS;

    vpp_cfg_decode u_dec (
        .word(word_q), .path(path_d), .fmt_ok(fmt_ok), .swz(swz),
        .blk_kind(blk_kind), .blk_h(blk_h), .w_m1(w_m1), .h_m1(h_m1)
    );

    assign path = path_d;

    vpp_exec_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .exec_hit(exec_hit),
        .luma_zero(luma_base == '0), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .fmt_ok(fmt_ok), .path(path_d), .swz(swz),
        .word_q(word_q), .mem_req(mem_req), .busy(busy), .start(start),
        .err_fmt(err_fmt), .err_noluma(err_noluma)
    );

    AST_NO_REQ_WITHOUT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !exec_hit) |=> !mem_req);   // R9
endmodule

// File: tb/sim_vpp_cmd_frontend.sv
module sim_vpp_cmd_frontend;
    logic clk = 0;
    logic rst_n = 0;
    logic mw_valid = 0;
    logic [5:0] mw_idx = 0;
    logic [31:0] mw_arg = 0;
    logic [5:0] rd_idx = 0;
    logic [31:0] rd_data;
    logic [39:0] cfg_base, luma_base, chu_base, chv_base, mem_addr;
    logic mem_req, mem_rvalid = 0, busy, start, swz, err_noluma, err_fmt;
    logic [63:0] mem_rdata = 0;
    logic [1:0] path;
    logic [3:0] blk_kind;
    logic [2:0] blk_h;
    logic [13:0] w_m1, h_m1;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [64];

    localparam logic [5:0] EXEC = 6'h08, CFG = 6'h10, LUMA = 6'h11, CHU = 6'h12, CHV = 6'h13;

    always #5 clk = ~clk;

    vpp_cmd_frontend u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_path(input logic [63:0] w);
        case (w[3:0])
            4'd1: return 2'd0;
            4'd2: return 2'd1;
            4'd3: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic exp_swz(input logic [63:0] w);
        return (exp_path(w) < 2'd2) && (w[7:4] != 4'd0);
    endfunction

    task automatic mwrite(input logic [5:0] idx, input logic [31:0] arg);
        @(negedge clk);
        mw_valid = 1; mw_idx = idx; mw_arg = arg;
        model[idx] = arg;
        @(negedge clk);
        mw_valid = 0;
    endtask

    task automatic check_word(input logic [5:0] idx);
        rd_idx = idx; #1;
        chk(rd_data == model[idx], "R1 mirror", rd_data, model[idx]);
    endtask

    task automatic do_exec(input logic [63:0] w, input int lat, input bit spam);
        logic [39:0] ea;
        ea = {model[CFG], 8'h00} + 40'h20;
        mwrite(EXEC, $urandom);
        chk(mem_req == 1, "R4 req", mem_req, 1);
        chk(mem_addr == ea, "R4 addr", mem_addr, ea);
        chk(busy == 1, "R5 busy req", busy, 1);
        for (int i = 0; i < lat; i++) begin
            if (spam) begin mw_valid = 1; mw_idx = EXEC; mw_arg = 32'h5A; model[EXEC] = 32'h5A; end
            @(negedge clk);
            mw_valid = 0;
            chk(mem_req == 0, "R5 no second req", mem_req, 0);
            chk(busy == 1, "R5 busy wait", busy, 1);
        end
        mem_rvalid = 1; mem_rdata = w;
        @(negedge clk);
        mem_rvalid = 0; mem_rdata = $urandom;
        if (exp_path(w) == 2'd3) begin
            chk(start == 0 && err_fmt == 1, "R6 bad fmt", {start, err_fmt}, 2'b01);
        end else begin
            chk(start == 1 && err_fmt == 0, "R6 start", {start, err_fmt}, 2'b10);
            chk(path == exp_path(w), "R6 path", path, exp_path(w));
            chk(swz == exp_swz(w), "R7 swz", swz, exp_swz(w));
            chk({blk_kind, blk_h, w_m1, h_m1} == {w[7:4], w[10:8], w[25:12], w[39:26]},
                "R8 fields", {blk_kind, blk_h, w_m1, h_m1}, {w[7:4], w[10:8], w[25:12], w[39:26]});
        end
        chk(busy == 1, "R5 busy done", busy, 1);
        @(negedge clk);
        chk(start == 0 && err_fmt == 0, "R8 one cycle", {start, err_fmt}, 0);
        chk(busy == 0, "R5 idle", busy, 0);
    endtask

    task automatic exec_noluma;
        mwrite(EXEC, 32'h1);
        chk(err_noluma == 1, "R3 err", err_noluma, 1);
        chk(mem_req == 0 && busy == 0, "R3 no req", {mem_req, busy}, 0);
        @(negedge clk);
        chk(err_noluma == 0, "R3 pulse", err_noluma, 0);
        chk(mem_req == 0 && busy == 0, "R3 still idle", {mem_req, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] w;
        void'($urandom(32'd7719));
        for (int i = 0; i < 64; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_word(CFG); check_word(6'h3F);
        chk({cfg_base, luma_base, chu_base, chv_base} == 0, "R2 reset", luma_base, 0);
        chk(busy == 0 && start == 0 && mem_req == 0, "R5 reset idle", busy, 0);

        exec_noluma();
        mwrite(CFG, 32'h0012_3400);
        exec_noluma();

        for (int i = 0; i < 40; i++) begin
            logic [5:0] idx;
            logic [31:0] a;
            idx = 6'($urandom_range(0, 63));
            if (idx == EXEC) idx = CHV;
            a = $urandom;
            mwrite(idx, a);
            check_word(idx);
            chk(busy == 0 && mem_req == 0, "R9 no start", {busy, mem_req}, 0);
        end
        mwrite(CFG, 32'hABCD_EF01);
        chk(cfg_base == 40'hAB_CDEF_0100, "R2 cfg", cfg_base, 40'hAB_CDEF_0100);
        mwrite(LUMA, 32'h0000_0040);
        chk(luma_base == 40'h00_0000_4000, "R2 luma", luma_base, 40'h4000);
        mwrite(CHU, 32'hFFFF_FFFF);
        chk(chu_base == 40'hFF_FFFF_FF00, "R2 chu", chu_base, 40'hFF_FFFF_FF00);
        mwrite(CHV, 32'h1);
        chk(chv_base == 40'h100, "R2 chv", chv_base, 40'h100);

        do_exec({24'h0, 14'd479, 14'd639, 1'b0, 3'd4, 4'd0, 4'd1}, 1, 0);
        do_exec({24'h0, 14'd100, 14'd200, 1'b0, 3'd2, 4'd5, 4'd1}, 3, 1);
        do_exec({24'hFF, 14'h3FFF, 14'h3FFF, 1'b1, 3'd7, 4'hF, 4'd2}, 2, 0);
        do_exec({24'h0, 14'd1, 14'd3, 1'b0, 3'd1, 4'd9, 4'd3}, 1, 1);
        do_exec({24'h0, 14'd5, 14'd5, 1'b0, 3'd0, 4'd2, 4'd0}, 1, 0);
        do_exec({24'h0, 14'd5, 14'd5, 1'b0, 3'd0, 4'd2, 4'hF}, 2, 0);
        check_word(EXEC);

        for (int i = 0; i < 25; i++) begin
            w = {$urandom, $urandom};
            w[3:0] = 4'($urandom_range(0, 4));
            if ($urandom_range(0, 3) == 0) mwrite(CFG, $urandom);
            do_exec(w, $urandom_range(1, 6), 1'($urandom_range(0, 1)));
        end

        mwrite(LUMA, 32'h0);
        exec_noluma();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule